// File: doc/BRIEF.md
# MII Management Register Slave

This block is the management end of a 10/100 PHY. It listens on the serial management line clocked by MDC, recognises frames that carry its own strapped PHY address, and serves reads and writes to a small bank of 16-bit registers. The bank holds the control word, the base status word, two read-only identifier words, an advertisement word, a live vendor status word, an interrupt mask, an interrupt event word and an LED configuration word.

Link, speed, duplex, transmit and receive activity and autonegotiation-complete arrive on plain side-band inputs. The block turns changes on these inputs into event bits. Each event bit is gated by a mask bit and drives an active-low interrupt pin. The link bit in the base status word latches low on a failure until software reads it. The event word clears when it is read. The reset bit in the control word clears itself once a soft reset has run.

Top module: `mii_mgmt_slave`

## Requirements
- R1: A frame has at least 32 preamble ones, then start bits 0 then 1, a 2-bit opcode (10 read, 01 write), a 5-bit PHY address, a 5-bit register address and 2 turnaround bits, followed by 16 data bits sent MSB first. A frame whose PHY address differs from `phy_addr_i` writes nothing, and `mdio_oe` stays low for the whole frame.
- R2: On a matching read, `mdio_oe` stays low during the first turnaround bit. The block drives 0 during the second turnaround bit and then drives the 16 data bits MSB first, each launched on a rising MDC edge. It releases `mdio_oe` after bit 0.
- R3: Register 2 reads `ID_HI` (default 0x2B47). Register 3 reads {OUI_LO[5:0] in [15:10], MODEL[5:0] in [9:4], REV[3:0] in [3:0]} (default 0x54E3). Writes to either register have no effect.
- R4: In register 0, bit 14 is loopback, bit 13 is speed select, bit 12 is autonegotiation enable, bit 11 is power-down, bit 10 is isolate, bit 9 is restart and bit 8 is duplex. Bits 14:6 are writable, bits 5:0 read 0, and the reset value is 0x3100. `ctrl_o` shows the register 0 value.
- R5: Writing register 0 with bit 15 set starts a soft reset lasting `RST_CYCLES` MDC cycles (default 64). While it runs, register 0 bit 15 reads 1 and writes to register 0 are ignored. When it ends, bit 15 reads 0 and registers 0, 4, 18, 19 and 20 return to their reset values.
- R6: Register 1 reads 0x7809 with bit 5 = live autonegotiation-complete and bit 2 = latched link. The latched link bit is 0 after hard reset, and any cycle with the link down forces it to 0. A read of register 1 reloads it with the live link value.
- R7: Register 17 is live status: bit 14 = 100 Mb/s, bit 13 = transmitting, bit 12 = receiving, bit 10 = link, bit 9 = full duplex, bit 7 = autonegotiation complete. All other bits read 0.
- R8: Register 18 is the event mask. Bits 7:4 are writable, and a 1 enables an event: bit 7 autonegotiation complete, bit 6 speed change, bit 5 duplex change, bit 4 link change. All other bits read 0, and the reset value is 0.
- R9: In register 19, bits 7:4 are event flags in the same order as the mask. Bit 7 sets on a rising edge of autonegotiation-complete. Bits 6:4 set on any change of speed, duplex or link (the link flag also sets on the first cycle after reset when the link is up). Bit 2 reads 1 when any flagged event is enabled. A read clears the event flags after returning their value.
- R10: `int_n_o` is low exactly while some event flag in register 19 has its mask bit set in register 18.
- R11: Register 4 (reset value 0x01E1) and register 20 (reset value 0x4220, shown on `led_cfg_o`) are fully writable. Any unlisted address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr_i | input | 5 | Strapped PHY address |
| mdio_i | input | 1 | Serial management data in |
| mdio_o | output | 1 | Serial management data out |
| mdio_oe | output | 1 | Output enable for mdio_o (tri-state control) |
| link_up_i | input | 1 | Live link status |
| speed100_i | input | 1 | 1 when running at 100 Mb/s |
| full_duplex_i | input | 1 | 1 when in full duplex |
| tx_active_i | input | 1 | Transmitting a packet |
| rx_active_i | input | 1 | Receiving a packet |
| an_done_i | input | 1 | Autonegotiation complete |
| int_n_o | output | 1 | Active-low interrupt |
| ctrl_o | output | 16 | Current control register value |
| led_cfg_o | output | 16 | Current LED configuration register value |

## Verification
The bench reads register 1 twice after a link blip. A design that does not latch the failure would report link up on the first read, and one that never reloads would keep reporting down. It reads the event word twice with the matching mask set and checks both the pin and bit 2. This catches a design that clears the flags before returning them, or one that ignores the mask. It reads register 0 both during and after a soft reset, which exposes a reset bit that never clears or clears without restoring the defaults. Foreign-address frames and writes to read-only or unlisted addresses must leave the line undriven and the registers unchanged.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam logic [4:0] REG_CTRL  = 5'd0;
    localparam logic [4:0] REG_STAT  = 5'd1;
    localparam logic [4:0] REG_ID1   = 5'd2;
    localparam logic [4:0] REG_ID2   = 5'd3;
    localparam logic [4:0] REG_ADV   = 5'd4;
    localparam logic [4:0] REG_VSTAT = 5'd17;
    localparam logic [4:0] REG_IMASK = 5'd18;
    localparam logic [4:0] REG_ISTAT = 5'd19;
    localparam logic [4:0] REG_LED   = 5'd20;

    localparam int PRE_ONES  = 32;
    localparam int DATA_BITS = 16;

    typedef enum logic [3:0] {
        S_PRE,
        S_ST,
        S_OP,
        S_PHY,
        S_REG,
        S_RTA1,
        S_RTA2,
        S_RDAT,
        S_WTA,
        S_WDAT
    } frame_st_e;

    typedef struct packed {
        frame_st_e   st;
        logic [5:0]  cnt;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] sh;
        logic        o;
        logic        oe;
    } rx_state_t;

endpackage

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
    import mii_mgmt_pkg::*;
(
    input  logic        mdc,
    input  logic        rst_n,
    input  logic [4:0]  phy_addr_i,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic [15:0] rd_data_i,
    output logic        rd_req_o,
    output logic [4:0]  rd_addr_o,
    output logic        wr_en_o,
    output logic [4:0]  wr_addr_o,
    output logic [15:0] wr_data_o
);

    rx_state_t  fr_d, fr_q;
    logic       phy_hit;
    logic [1:0] op_next;

    assign phy_hit = (fr_q.phy == phy_addr_i);
    assign op_next = {fr_q.op[0], mdio_i};

    always_comb begin
        fr_d      = fr_q;
        rd_req_o  = 1'b0;
        wr_en_o   = 1'b0;
        wr_data_o = {fr_q.sh[14:0], mdio_i};
        case (fr_q.st)
            S_PRE: begin
                if (mdio_i) begin
                    if (fr_q.cnt != 6'(PRE_ONES)) fr_d.cnt = fr_q.cnt + 6'd1;
                end else begin
                    if (fr_q.cnt == 6'(PRE_ONES)) fr_d.st = S_ST;
                    fr_d.cnt = 6'd0;
                end
            end
            S_ST: begin
                if (mdio_i) begin
                    fr_d.st  = S_OP;
                    fr_d.cnt = 6'd1;
                end else begin
                    fr_d.st  = S_PRE;
                    fr_d.cnt = 6'd0;
                end
            end
            S_OP: begin
                fr_d.op = op_next;
                if (fr_q.cnt == 6'd0) begin
                    if (op_next == 2'b10 || op_next == 2'b01) begin
                        fr_d.st  = S_PHY;
                        fr_d.cnt = 6'd4;
                    end else begin
                        fr_d.st  = S_PRE;
                        fr_d.cnt = 6'd0;
                    end
                end else begin
                    fr_d.cnt = fr_q.cnt - 6'd1;
                end
            end
            S_PHY: begin
                fr_d.phy = {fr_q.phy[3:0], mdio_i};
                if (fr_q.cnt == 6'd0) begin
                    fr_d.st  = S_REG;
                    fr_d.cnt = 6'd4;
                end else begin
                    fr_d.cnt = fr_q.cnt - 6'd1;
                end
            end
            S_REG: begin
                fr_d.regad = {fr_q.regad[3:0], mdio_i};
                if (fr_q.cnt == 6'd0) begin
                    if (fr_q.op == 2'b10) begin
                        fr_d.st = S_RTA1;
                    end else begin
                        fr_d.st  = S_WTA;
                        fr_d.cnt = 6'd1;
                    end
                end else begin
                    fr_d.cnt = fr_q.cnt - 6'd1;
                end
            end
            S_RTA1: begin
                rd_req_o = phy_hit;
                fr_d.st  = S_RTA2;
                fr_d.sh  = rd_data_i;
                fr_d.oe  = phy_hit;
                fr_d.o   = 1'b0;
            end
            S_RTA2: begin
                fr_d.st  = S_RDAT;
                fr_d.cnt = 6'(DATA_BITS - 1);
                fr_d.o   = fr_q.sh[15];
            end
            S_RDAT: begin
                if (fr_q.cnt == 6'd0) begin
                    fr_d.st  = S_PRE;
                    fr_d.oe  = 1'b0;
                    fr_d.o   = 1'b0;
                end else begin
                    fr_d.cnt = fr_q.cnt - 6'd1;
                    fr_d.o   = fr_q.sh[fr_q.cnt[3:0] - 4'd1];
                end
            end
            S_WTA: begin
                if (fr_q.cnt == 6'd0) begin
                    fr_d.st  = S_WDAT;
                    fr_d.cnt = 6'(DATA_BITS - 1);
                end else begin
                    fr_d.cnt = fr_q.cnt - 6'd1;
                end
            end
            S_WDAT: begin
                fr_d.sh = {fr_q.sh[14:0], mdio_i};
                if (fr_q.cnt == 6'd0) begin
                    wr_en_o  = phy_hit;
                    fr_d.st  = S_PRE;
                end else begin
                    fr_d.cnt = fr_q.cnt - 6'd1;
                end
            end
            default: begin
                fr_d.st  = S_PRE;
                fr_d.cnt = 6'd0;
            end
        endcase
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            fr_q.st    <= S_PRE;
            fr_q.cnt   <= 6'd0;
            fr_q.op    <= 2'b00;
            fr_q.phy   <= 5'd0;
            fr_q.regad <= 5'd0;
            fr_q.sh    <= 16'd0;
            fr_q.o     <= 1'b0;
            fr_q.oe    <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign mdio_o    = fr_q.o;
    assign mdio_oe_o = fr_q.oe;
    assign rd_addr_o = fr_q.regad;
    assign wr_addr_o = fr_q.regad;

    // R2: the first driven bit is the zero of the second turnaround bit
    assert_ta_zero_R2: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> (mdio_o == 1'b0));

    // R2: the line is released only after the last data bit
    assert_release_R2: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(mdio_oe_o) |-> $past(fr_q.st == S_RDAT));

    // R1: driving starts only after a read request for this PHY
    assert_drive_match_R1: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> $past(rd_req_o));

endmodule

// File: rtl/mii_reg_bank.sv
module mii_reg_bank
    import mii_mgmt_pkg::*;
#(
    parameter int          RST_CYCLES = 64,
    parameter logic [15:0] ID_HI      = 16'h2B47,
    parameter logic [5:0]  OUI_LO     = 6'h15,
    parameter logic [5:0]  MODEL      = 6'h0E,
    parameter logic [3:0]  REV        = 4'h3,
    parameter logic [15:0] ADV_DEF    = 16'h01E1,
    parameter logic [15:0] LED_DEF    = 16'h4220
) (
    input  logic        mdc,
    input  logic        rst_n,
    input  logic        rd_req_i,
    input  logic [4:0]  rd_addr_i,
    output logic [15:0] rd_data_o,
    input  logic        wr_en_i,
    input  logic [4:0]  wr_addr_i,
    input  logic [15:0] wr_data_i,
    input  logic        link_up_i,
    input  logic        speed100_i,
    input  logic        full_duplex_i,
    input  logic        tx_active_i,
    input  logic        rx_active_i,
    input  logic        an_done_i,
    output logic        int_n_o,
    output logic [15:0] ctrl_o,
    output logic [15:0] led_cfg_o
);

    localparam int          RST_W      = $clog2(RST_CYCLES + 1);
    localparam logic [14:0] CTRL_DEF   = 15'h3100;
    localparam logic [14:0] CTRL_WMASK = 15'h7FC0;
    localparam logic [15:0] STAT_FIXED = 16'h7809;

    typedef struct packed {
        logic [14:0]      ctrl;
        logic [15:0]      adv;
        logic [3:0]       mask;
        logic [15:0]      led;
        logic [3:0]       ev;
        logic             link_lat;
        logic [3:0]       prev;
        logic [RST_W-1:0] rst_cnt;
    } bank_t;

    bank_t      rb_d, rb_q;
    logic [3:0] live;
    logic [3:0] new_ev;
    logic       busy;
    logic       pending;
    logic       clr_ev;

    assign live    = {an_done_i, speed100_i, full_duplex_i, link_up_i};
    assign new_ev  = {an_done_i & ~rb_q.prev[3], live[2:0] ^ rb_q.prev[2:0]};
    assign busy    = (rb_q.rst_cnt != '0);
    assign pending = |(rb_q.ev & rb_q.mask);
    assign clr_ev  = rd_req_i && (rd_addr_i == REG_ISTAT);

    always_comb begin
        case (rd_addr_i)
            REG_CTRL:  rd_data_o = {busy, rb_q.ctrl};
            REG_STAT:  rd_data_o = STAT_FIXED | {10'd0, an_done_i, 2'b00, rb_q.link_lat, 2'b00};
            REG_ID1:   rd_data_o = ID_HI;
            REG_ID2:   rd_data_o = {OUI_LO, MODEL, REV};
            REG_ADV:   rd_data_o = rb_q.adv;
            REG_VSTAT: rd_data_o = {1'b0, speed100_i, tx_active_i, rx_active_i, 1'b0,
                                    link_up_i, full_duplex_i, 1'b0, an_done_i, 7'd0};
            REG_IMASK: rd_data_o = {8'd0, rb_q.mask, 4'd0};
            REG_ISTAT: rd_data_o = {8'd0, rb_q.ev, 1'b0, pending, 2'b00};
            REG_LED:   rd_data_o = rb_q.led;
            default:   rd_data_o = 16'd0;
        endcase
    end

    always_comb begin
        rb_d          = rb_q;
        rb_d.prev     = live;
        rb_d.ev       = (clr_ev ? 4'd0 : rb_q.ev) | new_ev;
        rb_d.link_lat = (rd_req_i && rd_addr_i == REG_STAT) ? link_up_i
                                                            : (rb_q.link_lat & link_up_i);
        if (wr_en_i) begin
            case (wr_addr_i)
                REG_CTRL: begin
                    if (!busy) begin
                        rb_d.ctrl = wr_data_i[14:0] & CTRL_WMASK;
                        if (wr_data_i[15]) rb_d.rst_cnt = RST_W'(RST_CYCLES);
                    end
                end
                REG_ADV:   rb_d.adv  = wr_data_i;
                REG_IMASK: rb_d.mask = wr_data_i[7:4];
                REG_LED:   rb_d.led  = wr_data_i;
                default: ;
            endcase
        end
        if (busy) begin
            rb_d.rst_cnt = rb_q.rst_cnt - 1'b1;
            if (rb_q.rst_cnt == RST_W'(1)) begin
                rb_d.ctrl = CTRL_DEF;
                rb_d.adv  = ADV_DEF;
                rb_d.mask = 4'd0;
                rb_d.led  = LED_DEF;
                rb_d.ev   = 4'd0;
            end
        end
    end

    always_ff @(posedge mdc or negedge rst_n) begin
        if (!rst_n) begin
            rb_q.ctrl     <= CTRL_DEF;
            rb_q.adv      <= ADV_DEF;
            rb_q.mask     <= 4'd0;
            rb_q.led      <= LED_DEF;
            rb_q.ev       <= 4'd0;
            rb_q.link_lat <= 1'b0;
            rb_q.prev     <= 4'd0;
            rb_q.rst_cnt  <= '0;
        end else begin
            rb_q <= rb_d;
        end
    end

    assign int_n_o   = ~pending;
    assign ctrl_o    = {busy, rb_q.ctrl};
    assign led_cfg_o = rb_q.led;

    // R6: a cycle with the link down leaves the latched bit at zero
    assert_link_latch_R6: assert property (@(posedge mdc) disable iff (!rst_n)
        !link_up_i |=> !rb_q.link_lat);

    // R9: reading the event word with no new event leaves it empty
    assert_clear_on_read_R9: assert property (@(posedge mdc) disable iff (!rst_n)
        (clr_ev && new_ev == 4'd0) |=> (rb_q.ev == 4'd0));

    // R5: the end of a soft reset restores the defaults
    assert_selfclear_R5: assert property (@(posedge mdc) disable iff (!rst_n)
        $fell(busy) |-> (rb_q.ctrl == CTRL_DEF && rb_q.mask == 4'd0));

    // R10: an enabled event pulls the interrupt low on the next cycle
    assert_irq_R10: assert property (@(posedge mdc) disable iff (!rst_n)
        (new_ev[3] && rb_q.mask[3] && !wr_en_i && !busy) |=> !int_n_o);

endmodule

// File: rtl/mii_mgmt_slave.sv
module mii_mgmt_slave #(
    parameter int          RST_CYCLES = 64,
    parameter logic [15:0] ID_HI      = 16'h2B47,
    parameter logic [5:0]  OUI_LO     = 6'h15,
    parameter logic [5:0]  MODEL      = 6'h0E,
    parameter logic [3:0]  REV        = 4'h3
) (
    input  logic        mdc,
    input  logic        rst_n,
    input  logic [4:0]  phy_addr_i,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        link_up_i,
    input  logic        speed100_i,
    input  logic        full_duplex_i,
    input  logic        tx_active_i,
    input  logic        rx_active_i,
    input  logic        an_done_i,
    output logic        int_n_o,
    output logic [15:0] ctrl_o,
    output logic [15:0] led_cfg_o
);

    logic        rd_req;
    logic [4:0]  rd_addr;
    logic [15:0] rd_data;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [15:0] wr_data;

    mii_frame_engine u_frame (
        .mdc       (mdc),
        .rst_n     (rst_n),
        .phy_addr_i(phy_addr_i),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .rd_data_i (rd_data),
        .rd_req_o  (rd_req),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    mii_reg_bank #(
        .RST_CYCLES(RST_CYCLES),
        .ID_HI     (ID_HI),
        .OUI_LO    (OUI_LO),
        .MODEL     (MODEL),
        .REV       (REV)
    ) u_bank (
        .mdc          (mdc),
        .rst_n        (rst_n),
        .rd_req_i     (rd_req),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .link_up_i    (link_up_i),
        .speed100_i   (speed100_i),
        .full_duplex_i(full_duplex_i),
        .tx_active_i  (tx_active_i),
        .rx_active_i  (rx_active_i),
        .an_done_i    (an_done_i),
        .int_n_o      (int_n_o),
        .ctrl_o       (ctrl_o),
        .led_cfg_o    (led_cfg_o)
    );

endmodule

// File: tb/mii_mgmt_slave_tb_top.sv
module mii_mgmt_slave_tb_top;

    localparam logic [4:0] MY_PHY    = 5'h11;
    localparam logic [4:0] OTHER_PHY = 5'h03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdio_o, mdio_oe;
    logic        link_up = 1'b1, speed100 = 1'b0, full_duplex = 1'b0;
    logic        tx_active = 1'b0, rx_active = 1'b0, an_done = 1'b0;
    logic        int_n;
    logic [15:0] ctrl, led_cfg;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    mii_mgmt_slave dut_i (
        .mdc          (clk),
        .rst_n        (rst_n),
        .phy_addr_i   (MY_PHY),
        .mdio_i       (mdio_i),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .link_up_i    (link_up),
        .speed100_i   (speed100),
        .full_duplex_i(full_duplex),
        .tx_active_i  (tx_active),
        .rx_active_i  (rx_active),
        .an_done_i    (an_done),
        .int_n_o      (int_n),
        .ctrl_o       (ctrl),
        .led_cfg_o    (led_cfg)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        mdio_i = b;
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
        for (int i = 0; i < 32; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    endtask

    task automatic mdio_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] val);
        send_hdr(2'b01, phy, ra);
        send_bit(1'b1);
        send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(val[i]);
        send_bit(1'b1);
        idle(2);
    endtask

    // scoreboard driver: expected word goes into the queue, monitor compares
    task automatic mdio_read(input logic [4:0] ra, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        send_hdr(2'b10, MY_PHY, ra);
        for (int i = 0; i < 18; i++) send_bit(1'b1);
        idle(3);
    endtask

    task automatic mdio_read_foreign(input logic [4:0] ra);
        bit driven = 1'b0;
        send_hdr(2'b10, OTHER_PHY, ra);
        for (int i = 0; i < 20; i++) begin
            send_bit(1'b1);
            if (mdio_oe) driven = 1'b1;
        end
        chk(!driven, "R1 foreign-address read left mdio undriven", {15'd0, driven}, 16'd0);
        idle(2);
    endtask

    // scoreboard monitor
    int          mon_cnt = 0;
    logic [15:0] mon_word = 16'd0;
    bit          rel_chk = 1'b0;
    always @(negedge clk) begin
        if (rel_chk) begin
            chk(!mdio_oe, "R2 release after bit 0", {15'd0, mdio_oe}, 16'd0);
            rel_chk = 1'b0;
        end else if (mon_cnt == 0) begin
            if (mdio_oe) begin
                chk(mdio_o == 1'b0, "R2 second turnaround bit is 0", {15'd0, mdio_o}, 16'd0);
                mon_cnt = 16;
            end
        end else begin
            if (!mdio_oe) chk(1'b0, "R2 driver dropped mid-word", 16'd0, 16'd1);
            mon_word = {mon_word[14:0], mdio_o};
            mon_cnt--;
            if (mon_cnt == 0) begin
                rel_chk = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected read data", mon_word, 16'hxxxx);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(mon_word === e, t, mon_word, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 16'd0, 16'd1);
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(3);
        // reset state
        chk(mdio_oe == 1'b0, "R1 reset: mdio undriven", {15'd0, mdio_oe}, 16'd0);
        chk(int_n == 1'b1, "R10 reset: int_n high", {15'd0, int_n}, 16'd1);
        chk(ctrl == 16'h3100, "R4 reset ctrl_o", ctrl, 16'h3100);
        chk(led_cfg == 16'h4220, "R11 reset led_cfg_o", led_cfg, 16'h4220);

        // identifiers, read-only
        mdio_read(5'd2, 16'h2B47, "R3 id word 2");
        mdio_read(5'd3, 16'h54E3, "R3 id word 3");
        mdio_write(MY_PHY, 5'd3, 16'hFFFF);
        mdio_read(5'd3, 16'h54E3, "R3 id word 3 after write");

        // control fields
        mdio_read(5'd0, 16'h3100, "R4 ctrl default");
        mdio_write(MY_PHY, 5'd0, 16'h413F);
        mdio_read(5'd0, 16'h4100, "R4 ctrl writable bits only");
        chk(ctrl == 16'h4100, "R4 ctrl_o after write", ctrl, 16'h4100);

        // advertisement and LED words
        mdio_write(MY_PHY, 5'd4, 16'hA5C3);
        mdio_read(5'd4, 16'hA5C3, "R11 adv readback");
        mdio_write(MY_PHY, 5'd20, 16'h1234);
        mdio_read(5'd20, 16'h1234, "R11 led readback");
        chk(led_cfg == 16'h1234, "R11 led_cfg_o after write", led_cfg, 16'h1234);

        // mask and pending link-up event from reset
        mdio_write(MY_PHY, 5'd18, 16'hFFFF);
        mdio_read(5'd18, 16'h00F0, "R8 mask writable bits");
        chk(int_n == 1'b0, "R10 enabled link event asserts int_n", {15'd0, int_n}, 16'd0);
        mdio_read(5'd19, 16'h0014, "R9 link event with pending bit");
        chk(int_n == 1'b1, "R10 int_n released after clear", {15'd0, int_n}, 16'd1);

        // soft reset
        mdio_write(MY_PHY, 5'd0, 16'hC000);
        mdio_read(5'd0, 16'hC000, "R5 reset bit reads 1 while busy");
        mdio_read(5'd0, 16'h3100, "R5 ctrl default after self-clear");
        chk(ctrl == 16'h3100, "R5 ctrl_o after self-clear", ctrl, 16'h3100);
        mdio_read(5'd18, 16'h0000, "R5 mask cleared by soft reset");
        mdio_read(5'd20, 16'h4220, "R5 led restored by soft reset");
        mdio_read(5'd4, 16'h01E1, "R5 adv restored by soft reset");

        // latch-low link
        mdio_read(5'd1, 16'h7809, "R6 latched low after hard reset");
        mdio_read(5'd1, 16'h780D, "R6 live after read");
        idle(1);
        link_up = 1'b0;
        idle(3);
        link_up = 1'b1;
        idle(3);
        chk(int_n == 1'b1, "R10 masked link event keeps int_n high", {15'd0, int_n}, 16'd1);
        mdio_read(5'd1, 16'h7809, "R6 failure latched");
        mdio_read(5'd1, 16'h780D, "R6 recovered after read");
        mdio_read(5'd19, 16'h0010, "R9 masked event flag, no pending");

        // live vendor status
        speed100 = 1'b1; full_duplex = 1'b1; tx_active = 1'b1;
        idle(3);
        mdio_read(5'd17, 16'h6600, "R7 speed/tx/link/duplex");
        tx_active = 1'b0; rx_active = 1'b1;
        idle(3);
        mdio_read(5'd17, 16'h5600, "R7 rx active");

        // enabled autonegotiation event
        mdio_write(MY_PHY, 5'd18, 16'h0080);
        chk(int_n == 1'b1, "R10 other events masked", {15'd0, int_n}, 16'd1);
        an_done = 1'b1;
        idle(3);
        chk(int_n == 1'b0, "R10 autoneg event asserts int_n", {15'd0, int_n}, 16'd0);
        mdio_read(5'd19, 16'h00E4, "R9 events before clear");
        chk(int_n == 1'b1, "R10 int_n high after clear", {15'd0, int_n}, 16'd1);
        mdio_read(5'd19, 16'h0000, "R9 cleared on read");

        // foreign address and unlisted registers
        mdio_read_foreign(5'd18);
        mdio_write(OTHER_PHY, 5'd18, 16'h00F0);
        mdio_read(5'd18, 16'h0080, "R1 foreign write ignored");
        mdio_write(MY_PHY, 5'd9, 16'hFFFF);
        mdio_read(5'd9, 16'h0000, "R11 unlisted address reads 0");
        mdio_read(5'd17, 16'h5680, "R7 autoneg complete bit");
        mdio_read(5'd1, 16'h782D, "R6 autoneg bit and live link");

        idle(10);
        chk(exp_q.size() == 0, "R2 all reads returned data", 16'(exp_q.size()), 16'd0);
        finish_run();
    end

endmodule